// File: doc/BRIEF.md
# Comparator Metastability Timeout Guard

This block sits beside a dynamic latch comparator in an asynchronous successive-approximation converter and decides, once per comparison, when the comparison is over and which bit it produced. The comparator strobe (`cmp_clk`) and the two latch outputs are sampled on the system clock. While the strobe is low, both latch outputs rest high. After the strobe rises, the guard waits for exactly one of them to drop. The side that drops gives the result bit, and the guard emits a one-cycle completion pulse.

A comparison can also run with an input difference near zero. The latch then hangs between its states or releases both sides together. So that the converter never waits without end, the guard runs a window timer from the strobe's rising edge. The window length comes from a small input. If no clean decision has appeared when the window closes, the guard still completes. In that case it takes the result bit from a pseudorandom sequence and raises a forced flag alongside the completion pulse. At that resolution the value of the bit does not change the final code, so a pseudorandom value is acceptable.

Top module: `cmp_timeout_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `done_o`, `tmo_o` and `bit_o` are 0. The pseudorandom register reloads to 7'b0000001.
- R2: Suppose the guard samples `cmp_clk` high on edge E0 and exactly one latch output low on a later edge Ek. Then `done_o` is 1 for exactly the one cycle after Ek, and `tmo_o` stays 0.
- R3: For a clean decision, `bit_o` is 1 when `lat_qn` was the output that went low and 0 when `lat_q` went low.
- R4: Let L be `tmo_len`, with 0 treated as 1. If no latch output is low on edges E1..EL, the guard completes after EL with `done_o` = 1 and `tmo_o` = 1.
- R5: When a clean decision and the window close fall on the same edge EL, the clean decision wins: the real bit is kept and `tmo_o` = 0.
- R6: Both latch outputs low on the same sampled edge counts as metastable. The decision is forced, with `tmo_o` = 1 and the bit taken from the pseudorandom source.
- R7: The forced bit is bit 6 of a 7-bit register that shifts left. Its new bit 0 is bit 6 XOR bit 5, which is the polynomial x^7+x^6+1. The register advances only on a forced decision.
- R8: Only one decision is made per high phase of `cmp_clk`. Latch changes after a decision, and a clean decision that arrives after the window has closed, are ignored until `cmp_clk` is sampled low.
- R9: If `cmp_clk` is sampled low before any decision, the comparison is dropped with no pulse.
- R10: `bit_o` holds its last decided value between decisions. `tmo_len` must be held stable while `cmp_clk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_clk | input | 1 | Comparator strobe, high during evaluation |
| lat_q | input | 1 | Positive latch output, high at rest |
| lat_qn | input | 1 | Negative latch output, high at rest |
| tmo_len | input | 6 | Decision window in system cycles (0 means 1) |
| done_o | output | 1 | One-cycle completion pulse |
| bit_o | output | 1 | Resolved comparison bit, held |
| tmo_o | output | 1 | Marks a forced (pseudorandom) decision, pulses with done_o |

## Verification
Each side of the latch is made to fall at several delays inside the window, which separates the bit polarity and the completion latency. Decisions placed exactly on the closing edge, just past it, and with a window value of zero probe where the guard switches between a clean decision and a forced one. Releasing both outputs together tells the tie path apart from the timeout path. A run of back-to-back timeouts compares the forced bits against an independent model of the shift register. An abandoned strobe phase and a second latch fall after a decision confirm that neither produces an extra pulse.

// File: rtl/cmpg_pkg.sv
package cmpg_pkg;

    localparam int LEN_W   = 6;
    localparam int PN_W    = 7;
    localparam int PN_TAPB = 5;
    localparam logic [PN_W-1:0] PN_SEED = 7'b0000001;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WATCH = 2'd1,
        PH_HOLD  = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        LV_NONE   = 2'd0,
        LV_LOW_Q  = 2'd1,
        LV_LOW_QN = 2'd2,
        LV_BOTH   = 2'd3
    } latch_view_t;

    typedef struct packed {
        logic strobe;
        logic bit_v;
        logic forced;
    } verdict_t;

    function automatic latch_view_t view_latch(input logic q, input logic qn);
        latch_view_t v;
        case ({q, qn})
            2'b11:   v = LV_NONE;
            2'b01:   v = LV_LOW_Q;
            2'b10:   v = LV_LOW_QN;
            default: v = LV_BOTH;
        endcase
        return v;
    endfunction

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
        return (l == '0) ? LEN_W'(1) : l;
    endfunction

endpackage

// File: rtl/cmpg_pn_source.sv
module cmpg_pn_source
    import cmpg_pkg::*;
#(
    parameter int W = PN_W,
    parameter int TAPB = PN_TAPB,
    parameter logic [W-1:0] SEED = PN_SEED
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output logic pn_bit
);
    logic [W-1:0] state_q;
    logic         fb;

    generate
        if (TAPB >= 0 && TAPB < W - 1) begin : g_two_tap
            assign fb = state_q[W-1] ^ state_q[TAPB];
        end else begin : g_self_tap
            assign fb = ~state_q[W-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (advance) begin
            state_q <= {state_q[W-2:0], fb};
        end
    end

    assign pn_bit = state_q[W-1];
endmodule

// File: rtl/cmpg_window_timer.sv
module cmpg_window_timer
    import cmpg_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [LW-1:0] len,
    output logic          expired
);
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] limit;

    assign limit   = (len == '0) ? LW'(1) : len;
    assign expired = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LW'(1);
        end else if (run && !expired) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end
endmodule

// File: rtl/cmpg_phase_ctrl.sv
module cmpg_phase_ctrl
    import cmpg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmp_clk,
    input  latch_view_t view,
    input  logic        expired,
    input  logic        pn_bit,
    output logic        timer_load,
    output logic        timer_run,
    output logic        pn_adv,
    output verdict_t    verdict
);
    phase_t   ph_q, ph_d;
    verdict_t vd_q;
    logic     watching, decide, forced_now, val_now;

    assign watching   = (ph_q == PH_WATCH) && cmp_clk;
    assign timer_load = (ph_q == PH_IDLE) && cmp_clk;
    assign timer_run  = watching;

    always_comb begin
        decide     = 1'b0;
        forced_now = 1'b0;
        val_now    = 1'b0;
        if (watching) begin
            unique case (view)
                LV_LOW_Q:  begin decide = 1'b1; val_now = 1'b0; end
                LV_LOW_QN: begin decide = 1'b1; val_now = 1'b1; end
                LV_BOTH:   begin decide = 1'b1; forced_now = 1'b1; val_now = pn_bit; end
                default: begin
                    if (expired) begin
                        decide     = 1'b1;
                        forced_now = 1'b1;
                        val_now    = pn_bit;
                    end
                end
            endcase
        end
    end

    assign pn_adv = forced_now;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:  if (cmp_clk) ph_d = PH_WATCH;
            PH_WATCH: begin
                if (!cmp_clk)    ph_d = PH_IDLE;
                else if (decide) ph_d = PH_HOLD;
            end
            PH_HOLD:  if (!cmp_clk) ph_d = PH_IDLE;
            default:  ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
            vd_q <= '0;
        end else begin
            ph_q        <= ph_d;
            vd_q.strobe <= decide;
            vd_q.forced <= forced_now;
            if (decide) vd_q.bit_v <= val_now;
        end
    end

    assign verdict = vd_q;
endmodule

// File: rtl/cmp_timeout_guard.sv
module cmp_timeout_guard
    import cmpg_pkg::*;
#(
    parameter int LW   = LEN_W,
    parameter int PW   = PN_W,
    parameter int TAPB = PN_TAPB,
    parameter logic [PW-1:0] SEED = PN_SEED
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_clk,
    input  logic          lat_q,
    input  logic          lat_qn,
    input  logic [LW-1:0] tmo_len,
    output logic          done_o,
    output logic          bit_o,
    output logic          tmo_o
);
    latch_view_t view;
    logic        expired, pn_bit, pn_adv, t_load, t_run;
    verdict_t    verdict;

    assign view = view_latch(lat_q, lat_qn);

    cmpg_window_timer #(.LW(LW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .run(t_run),
        .len(tmo_len), .expired(expired)
    );

    cmpg_pn_source #(.W(PW), .TAPB(TAPB), .SEED(SEED)) u_pn (
        .clk(clk), .rst(rst), .advance(pn_adv), .pn_bit(pn_bit)
    );

    cmpg_phase_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmp_clk(cmp_clk), .view(view),
        .expired(expired), .pn_bit(pn_bit), .timer_load(t_load),
        .timer_run(t_run), .pn_adv(pn_adv), .verdict(verdict)
    );

    assign done_o = verdict.strobe;
    assign bit_o  = verdict.bit_v;
    assign tmo_o  = verdict.forced;
endmodule

// File: rtl/cmpg_guard_sva.sv
module cmpg_guard_sva #(
    parameter int LW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cmp_clk,
    input logic          lat_q,
    input logic          lat_qn,
    input logic [LW-1:0] tmo_len,
    input logic          done_o,
    input logic          bit_o,
    input logic          tmo_o
);
    logic       seen_q;
    logic [7:0] wc_q;
    logic [7:0] lim;

    assign lim = (tmo_len == '0) ? 8'd1 : 8'(tmo_len);

    always_ff @(posedge clk) begin
        if (rst || !cmp_clk) begin
            seen_q <= 1'b0;
            wc_q   <= '0;
        end else begin
            seen_q <= seen_q | done_o;
            if (!(seen_q || done_o) && wc_q != 8'hff) wc_q <= wc_q + 8'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !done_o && !tmo_o && !bit_o);
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);
    a_r2_needs_strobe: assert property (@(posedge clk) disable iff (rst) done_o |-> $past(cmp_clk));
    a_r3_real_bit: assert property (@(posedge clk) disable iff (rst)
        (done_o && !tmo_o) |-> (($past(lat_q) != $past(lat_qn)) && (bit_o == !$past(lat_qn))));
    a_r4_window_bound: assert property (@(posedge clk) disable iff (rst)
        (cmp_clk && !seen_q && !done_o) |-> (wc_q <= lim));
    a_r4_flag_with_done: assert property (@(posedge clk) disable iff (rst) tmo_o |-> done_o);
    a_r6_tie_forced: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(!lat_q && !lat_qn)) |-> tmo_o);
    a_r8_once_per_phase: assert property (@(posedge clk) disable iff (rst)
        (seen_q && cmp_clk) |-> !done_o);
    a_r10_bit_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(bit_o));
endmodule

bind cmp_timeout_guard cmpg_guard_sva #(.LW(LW)) u_sva (
    .clk(clk), .rst(rst), .cmp_clk(cmp_clk), .lat_q(lat_q), .lat_qn(lat_qn),
    .tmo_len(tmo_len), .done_o(done_o), .bit_o(bit_o), .tmo_o(tmo_o)
);

// File: tb/cmp_timeout_guard_test.sv
module cmp_timeout_guard_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_clk = 1'b0;
    logic       lat_q = 1'b1;
    logic       lat_qn = 1'b1;
    logic [5:0] tmo_len = 6'd4;
    logic       done_o, bit_o, tmo_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [6:0] pn_model = 7'b0000001;
    logic       last_bit = 1'b0;

    typedef struct {
        logic  b;
        logic  t;
        int    at;
        string req;
    } exp_t;
    exp_t sb[$];

    cmp_timeout_guard uut (
        .clk(clk), .rst(rst), .cmp_clk(cmp_clk), .lat_q(lat_q), .lat_qn(lat_qn),
        .tmo_len(tmo_len), .done_o(done_o), .bit_o(bit_o), .tmo_o(tmo_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    // monitor: pop expected verdicts when the design pulses done_o
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                chk("R8/R9", 1, 0, "unexpected done_o pulse");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, bit_o, e.b, "bit_o");
                chk(e.req, tmo_o, e.t, "tmo_o");
                chk(e.req, cyc, e.at, "done cycle");
            end
        end
    end

    // kind: 0 Q falls, 1 QN falls, 2 both fall, 3 nothing, 4 strobe dropped, 5 Q then QN falls
    task automatic run_cmp(input int len, input int kind, input int k, input string req);
        int   leff, m, span;
        logic forced, b;
        exp_t e;
        leff = (len == 0) ? 1 : len;
        @(negedge clk);
        tmo_len = 6'(len);
        cmp_clk = 1'b1;
        lat_q = 1'b1;
        lat_qn = 1'b1;
        if (kind == 4 && k <= leff) begin
            m = -1;
        end else if ((kind <= 2 || kind == 5) && k <= leff) begin
            m = k;
            forced = (kind == 2);
            b = (kind == 1);
        end else begin
            m = leff;
            forced = 1'b1;
        end
        if (m >= 0) begin
            if (forced) begin
                b = pn_model[6];
                pn_model = {pn_model[5:0], pn_model[6] ^ pn_model[5]};
            end
            e.b = b; e.t = forced; e.at = cyc + 1 + m; e.req = req;
            sb.push_back(e);
            last_bit = b;
        end
        repeat (k) @(negedge clk);
        case (kind)
            0, 5: lat_q = 1'b0;
            1: lat_qn = 1'b0;
            2: begin lat_q = 1'b0; lat_qn = 1'b0; end
            4: cmp_clk = 1'b0;
            default: ;
        endcase
        if (kind == 5) begin
            @(negedge clk);
            lat_qn = 1'b0;
        end
        span = ((k > leff) ? k : leff) + 3;
        repeat (span - k) @(negedge clk);
        cmp_clk = 1'b0;
        lat_q = 1'b1;
        lat_qn = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", bit_o, last_bit, "bit_o held between decisions");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", done_o, 0, "done_o in reset");
        chk("R1", tmo_o, 0, "tmo_o in reset");
        chk("R1", bit_o, 0, "bit_o in reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_cmp(8, 1, 3, "R2 R3 qn low");
        run_cmp(8, 0, 2, "R2 R3 q low");
        run_cmp(8, 1, 1, "R2 first edge");
        run_cmp(5, 0, 5, "R5 tie-break q");
        run_cmp(5, 1, 5, "R5 tie-break qn");
        run_cmp(4, 3, 0, "R4 timeout");
        run_cmp(0, 3, 0, "R4 zero len");
        run_cmp(0, 1, 1, "R5 zero len real");
        run_cmp(6, 2, 2, "R6 both low");
        run_cmp(3, 0, 6, "R8 late decision");
        run_cmp(6, 5, 2, "R8 second fall");
        run_cmp(7, 4, 3, "R9 dropped strobe");
        for (int i = 0; i < 10; i++) run_cmp(2, 3, 0, "R7 pn sequence");
        run_cmp(63, 1, 40, "R2 long window");
        run_cmp(63, 3, 0, "R4 max window");
        run_cmp(2, 0, 1, "R3 after forced");

        repeat (4) @(negedge clk);
        chk("R9", sb.size(), 0, "pending verdicts");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule